// File: doc/BRIEF.md
# Dual-Issue Structural Hazard Scheduler

This block sits at the issue stage of a small in-order core. Each cycle it receives up to two decoded instruction class codes in program order. Lane 0 is the older instruction and lane 1 the younger. For each class it holds a reservation pattern: which resources the instruction needs, and at which cycle offset after it is presented. Offset 0 is the decode cycle and offset 1 is the issue cycle. The resources are:

- decode, issue and retire slots, two of each;
- two simple integer units;
- a four-stage pipelined multiplier;
- a divider that cannot pipeline;
- a load/store unit;
- a floating-point unit;
- a branch unit.

An instruction is granted only if every resource in its pattern is free at every offset it needs. Its bookings are then written into a table of future cycles. The table advances by one entry each clock.

Where a resource comes as a pair (decode, issue, retire, simple unit), the lower-numbered member is taken whenever it is free. The upper member is used only when the lower one is already booked for that cycle. With each grant the block reports the instruction's result latency.

Operand dependencies, fetch and arithmetic are handled elsewhere. Grants and latencies are combinational in the cycle the request is presented. The bookings of granted instructions take effect from the next clock edge.

Top module: `dual_issue_hazard_sched`

## Requirements
- R1: Synchronous active-high `rst` empties the booking table. After reset, any class is granted at once, even one that was blocked just before the reset by a long unit hold. With both valids low, neither grant is asserted.
- R2: Lane 1 is granted only when lane 1 is valid and lane 0 is both valid and granted in the same cycle. A stalled lane 0 always stalls lane 1.
- R3: Simple class (code 0) books one issue slot, one simple unit and one retire slot at offset 1. In each pair, slot 0 is taken when free and slot 1 otherwise. For example, a simple instruction paired with a move-to-condition class (code 7) leaves simple unit 1 for the younger instruction, so both are granted.
- R4: Compare class (code 1) books issue and a simple unit at offset 1 and its retire slot at offset 2. Two compares fill the retire slots of that cycle.
- R5: Two-part class (code 2) repeats the issue + simple unit + retire booking at offsets 1 and 2. Three-part class (code 3) repeats it at offsets 1, 2 and 3.
- R6: Multiply class (code 4) uses multiplier stage 0 at offset 1 and stages 1, 2 and 3 at offsets 2, 3 and 4. It retires with stage 3. A multiply can be granted every cycle, but only one per cycle.
- R7: Divide class (code 5) uses multiplier stage 0 at offset 1 and holds the divider over offsets 1 to 14. A later divide is refused for 13 cycles after a granted one and accepted on the 14th.
- R8: Move-from-condition class (code 6) must use simple unit 1 and holds it over offsets 1 to 4, with retire at offset 2. Move-to-condition class (code 7) must use simple unit 1, at offset 1 only.
- R9: Branch class (code 8) books the branch unit at offset 1 and a retire slot at offset 2, and uses no issue slot. Only one branch is granted per cycle.
- R10: Load/store class (code 9) books issue and the load/store unit at offset 1 and retires at offset 3. Floating-point load class (code 10) does the same but retires at offset 4. At most one of these classes is granted per cycle.
- R11: Floating-point class (code 11) holds the FPU at offset 1 only. Single divide (code 12) holds it over offsets 1 to 20. Double divide (code 13) holds it over offsets 1 to 35.
- R12: The 6-bit latency output of a granted lane is:

  | Codes | Latency |
  |---|---|
  | 0, 7, 8 | 1 |
  | 1, 2 | 2 |
  | 3, 9 | 3 |
  | 4, 6, 10 | 4 |
  | 5 | 14 |
  | 11 | 7 |
  | 12 | 20 |
  | 13 | 35 |

  Codes 14 and 15 are handled exactly as code 0. An ungranted lane reports latency 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, empties the booking table |
| in0_valid | input | 1 | Older instruction present |
| in0_class | input | 4 | Class code of the older instruction |
| in1_valid | input | 1 | Younger instruction present |
| in1_class | input | 4 | Class code of the younger instruction |
| grant0 | output | 1 | Older instruction issues this cycle |
| lat0 | output | 6 | Result latency of the older instruction, 0 when not granted |
| grant1 | output | 1 | Younger instruction issues this cycle |
| lat1 | output | 6 | Result latency of the younger instruction, 0 when not granted |

## Verification
The bench aims at these corner cases:

- A simple instruction paired with a move-to-condition instruction. A design that gives the simple unit pair to the upper member first refuses the younger instruction.
- A simple instruction offered right after two compares. It should collide only on retire slots. A design that books compare retirement at issue time grants it.
- A divide offered 13 and then 14 cycles after a granted divide, a single divide offered 19 and then 20 cycles after a granted one, and a floating-point operation offered 34 and then 35 cycles after a double divide. A design whose hold or table depth is off by one grants too early or stalls one cycle too long.
- A granted branch next to a refused simple instruction, and a younger instruction left behind a stalled older one. A design that charges branches an issue slot refuses the branch. A design that lets lane 1 run alone issues out of order.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int NUM_RES     = 17;
    localparam int LAT_W       = 6;
    localparam int DIV_HOLD    = 14;
    localparam int MFCR_HOLD   = 4;
    localparam int FDIVS_HOLD  = 20;
    localparam int FDIVD_HOLD  = 35;
    localparam int MIN_HORIZON = FDIVD_HOLD + 1;

    // Resource bit positions inside a booking vector
    localparam int RES_DEC0 = 0;
    localparam int RES_DEC1 = 1;
    localparam int RES_ISS0 = 2;
    localparam int RES_ISS1 = 3;
    localparam int RES_SU0  = 4;
    localparam int RES_SU1  = 5;
    localparam int RES_MU0  = 6;
    localparam int RES_DIV  = 10;
    localparam int RES_LSU  = 11;
    localparam int RES_FPU  = 12;
    localparam int RES_BU   = 13;
    localparam int RES_RET0 = 14;
    localparam int RES_RET1 = 15;
    localparam int RES_SPARE = 16;

    typedef enum logic [3:0] {
        IC_SIMPLE = 4'd0,
        IC_CMP    = 4'd1,
        IC_TWO    = 4'd2,
        IC_THREE  = 4'd3,
        IC_MUL    = 4'd4,
        IC_DIV    = 4'd5,
        IC_MFCR   = 4'd6,
        IC_MTCR   = 4'd7,
        IC_BRANCH = 4'd8,
        IC_LDST   = 4'd9,
        IC_FPLD   = 4'd10,
        IC_FP     = 4'd11,
        IC_FDIVS  = 4'd12,
        IC_FDIVD  = 4'd13
    } iclass_e;

    typedef logic [NUM_RES-1:0] resv_t;

    // Needs of one instruction at one cycle offset
    typedef struct packed {
        logic       dec;
        logic       iss;
        logic       su;
        logic       su1;
        logic       ret;
        logic [3:0] mu;
        logic       div;
        logic       lsu;
        logic       fpu;
        logic       bu;
    } demand_t;

    function automatic iclass_e decode_class(input logic [3:0] code);
        iclass_e c;
        if (code > 4'd13) c = IC_SIMPLE;
        else              c = iclass_e'(code);
        return c;
    endfunction

    function automatic logic in_span(input int unsigned k, input int unsigned last);
        return (k >= 1) && (k <= last);
    endfunction

    function automatic demand_t class_demand(input iclass_e c, input int unsigned k);
        demand_t d;
        d = '0;
        d.dec = (k == 0);
        unique case (c)
            IC_CMP: begin
                d.iss = (k == 1);
                d.su  = (k == 1);
                d.ret = (k == 2);
            end
            IC_TWO: begin
                d.iss = in_span(k, 2);
                d.su  = in_span(k, 2);
                d.ret = in_span(k, 2);
            end
            IC_THREE: begin
                d.iss = in_span(k, 3);
                d.su  = in_span(k, 3);
                d.ret = in_span(k, 3);
            end
            IC_MUL: begin
                d.iss   = (k == 1);
                d.mu[0] = (k == 1);
                d.mu[1] = (k == 2);
                d.mu[2] = (k == 3);
                d.mu[3] = (k == 4);
                d.ret   = (k == 4);
            end
            IC_DIV: begin
                d.iss   = (k == 1);
                d.mu[0] = (k == 1);
                d.div   = in_span(k, DIV_HOLD);
            end
            IC_MFCR: begin
                d.iss = (k == 1);
                d.su1 = in_span(k, MFCR_HOLD);
                d.ret = (k == 2);
            end
            IC_MTCR: begin
                d.iss = (k == 1);
                d.su1 = (k == 1);
                d.ret = (k == 1);
            end
            IC_BRANCH: begin
                d.bu  = (k == 1);
                d.ret = (k == 2);
            end
            IC_LDST: begin
                d.iss = (k == 1);
                d.lsu = (k == 1);
                d.ret = (k == 3);
            end
            IC_FPLD: begin
                d.iss = (k == 1);
                d.lsu = (k == 1);
                d.ret = (k == 4);
            end
            IC_FP: begin
                d.iss = (k == 1);
                d.fpu = (k == 1);
            end
            IC_FDIVS: begin
                d.iss = (k == 1);
                d.fpu = in_span(k, FDIVS_HOLD);
            end
            IC_FDIVD: begin
                d.iss = (k == 1);
                d.fpu = in_span(k, FDIVD_HOLD);
            end
            default: begin
                d.iss = (k == 1);
                d.su  = (k == 1);
                d.ret = (k == 1);
            end
        endcase
        return d;
    endfunction

    function automatic logic [LAT_W-1:0] class_latency(input iclass_e c);
        logic [LAT_W-1:0] l;
        unique case (c)
            IC_CMP, IC_TWO:           l = LAT_W'(2);
            IC_THREE, IC_LDST:        l = LAT_W'(3);
            IC_MUL, IC_MFCR, IC_FPLD: l = LAT_W'(4);
            IC_DIV:                   l = LAT_W'(DIV_HOLD);
            IC_FP:                    l = LAT_W'(7);
            IC_FDIVS:                 l = LAT_W'(FDIVS_HOLD);
            IC_FDIVD:                 l = LAT_W'(FDIVD_HOLD);
            default:                  l = LAT_W'(1);
        endcase
        return l;
    endfunction

    // Pick from a resource pair: {fail, take_hi, take_lo}
    function automatic logic [2:0] take_pair(input logic need, input logic busy_lo,
                                             input logic busy_hi);
        logic [2:0] r;
        r = 3'b000;
        if (need) begin
            if (!busy_lo)      r = 3'b001;
            else if (!busy_hi) r = 3'b010;
            else               r = 3'b100;
        end
        return r;
    endfunction

    // Claim a single resource: {fail, take}
    function automatic logic [1:0] take_one(input logic need, input logic busy);
        logic [1:0] r;
        r = 2'b00;
        if (need) r = busy ? 2'b10 : 2'b01;
        return r;
    endfunction

endpackage

// File: rtl/sched_pattern_gen.sv
module sched_pattern_gen
    import sched_pkg::*;
#(
    parameter int HORIZON = 36
) (
    input  iclass_e cls,
    output demand_t dem [HORIZON]
);
    for (genvar k = 0; k < HORIZON; k++) begin : g_off
        assign dem[k] = class_demand(cls, k);
    end
endmodule

// File: rtl/sched_slot_alloc.sv
module sched_slot_alloc
    import sched_pkg::*;
(
    input  resv_t   busy,
    input  demand_t need,
    output logic    fit,
    output resv_t   claim
);
    localparam int MU_STAGES = 4;

    logic [2:0] p_dec, p_iss, p_su, p_ret;
    logic [1:0] s_su1, s_div, s_lsu, s_fpu, s_bu;
    logic [1:0] s_mu [MU_STAGES];

    always_comb begin
        p_dec = take_pair(need.dec, busy[RES_DEC0], busy[RES_DEC1]);
        p_iss = take_pair(need.iss, busy[RES_ISS0], busy[RES_ISS1]);
        p_su  = take_pair(need.su,  busy[RES_SU0],  busy[RES_SU1]);
        p_ret = take_pair(need.ret, busy[RES_RET0], busy[RES_RET1]);
        s_su1 = take_one(need.su1, busy[RES_SU1]);
        s_div = take_one(need.div, busy[RES_DIV]);
        s_lsu = take_one(need.lsu, busy[RES_LSU]);
        s_fpu = take_one(need.fpu, busy[RES_FPU]);
        s_bu  = take_one(need.bu,  busy[RES_BU]);
        for (int i = 0; i < MU_STAGES; i++) begin
            s_mu[i] = take_one(need.mu[i], busy[RES_MU0+i]);
        end
    end

    always_comb begin
        claim = '0;
        claim[RES_DEC0] = p_dec[0];
        claim[RES_DEC1] = p_dec[1];
        claim[RES_ISS0] = p_iss[0];
        claim[RES_ISS1] = p_iss[1];
        claim[RES_SU0]  = p_su[0];
        claim[RES_SU1]  = p_su[1] | s_su1[0];
        claim[RES_RET0] = p_ret[0];
        claim[RES_RET1] = p_ret[1];
        claim[RES_DIV]  = s_div[0];
        claim[RES_LSU]  = s_lsu[0];
        claim[RES_FPU]  = s_fpu[0];
        claim[RES_BU]   = s_bu[0];
        claim[RES_SPARE] = 1'b0;
        fit = !(p_dec[2] | p_iss[2] | p_su[2] | p_ret[2] |
                s_su1[1] | s_div[1] | s_lsu[1] | s_fpu[1] | s_bu[1]);
        for (int i = 0; i < MU_STAGES; i++) begin
            claim[RES_MU0+i] = s_mu[i][0];
            if (s_mu[i][1]) fit = 1'b0;
        end
    end
endmodule

// File: rtl/sched_resv_table.sv
module sched_resv_table
    import sched_pkg::*;
#(
    parameter int HORIZON = 36
) (
    input  logic  clk,
    input  logic  rst,
    input  resv_t commit [HORIZON],
    output resv_t occ    [HORIZON]
);
    resv_t occ_q [HORIZON];

    for (genvar k = 0; k < HORIZON; k++) begin : g_row
        if (k < HORIZON - 1) begin : g_shift
            always_ff @(posedge clk) begin
                if (rst) occ_q[k] <= '0;
                else     occ_q[k] <= occ_q[k+1] | commit[k+1];
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                occ_q[k] <= '0;
            end
        end
        assign occ[k] = occ_q[k];
    end
endmodule

// File: rtl/dual_issue_hazard_sched.sv
module dual_issue_hazard_sched
    import sched_pkg::*;
#(
    parameter int HORIZON = MIN_HORIZON
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in0_valid,
    input  logic [3:0]       in0_class,
    input  logic             in1_valid,
    input  logic [3:0]       in1_class,
    output logic             grant0,
    output logic [LAT_W-1:0] lat0,
    output logic             grant1,
    output logic [LAT_W-1:0] lat1
);
    iclass_e cls0, cls1;
    demand_t dem0 [HORIZON];
    demand_t dem1 [HORIZON];
    resv_t   occ    [HORIZON];
    resv_t   claim0 [HORIZON];
    resv_t   claim1 [HORIZON];
    resv_t   busy1  [HORIZON];
    resv_t   commit [HORIZON];
    logic [HORIZON-1:0] fit0, fit1;

    assign cls0 = decode_class(in0_class);
    assign cls1 = decode_class(in1_class);

    sched_pattern_gen #(.HORIZON(HORIZON)) pat0_i (.cls(cls0), .dem(dem0));
    sched_pattern_gen #(.HORIZON(HORIZON)) pat1_i (.cls(cls1), .dem(dem1));

    for (genvar k = 0; k < HORIZON; k++) begin : g_lane
        sched_slot_alloc alloc0_i (
            .busy (occ[k]),
            .need (dem0[k]),
            .fit  (fit0[k]),
            .claim(claim0[k])
        );
        // The younger instruction sees the older one's bookings as taken
        assign busy1[k] = occ[k] | (grant0 ? claim0[k] : '0);
        sched_slot_alloc alloc1_i (
            .busy (busy1[k]),
            .need (dem1[k]),
            .fit  (fit1[k]),
            .claim(claim1[k])
        );
        assign commit[k] = (grant0 ? claim0[k] : '0) | (grant1 ? claim1[k] : '0);
    end

    assign grant0 = in0_valid && (&fit0);
    assign grant1 = grant0 && in1_valid && (&fit1);
    assign lat0   = grant0 ? class_latency(cls0) : '0;
    assign lat1   = grant1 ? class_latency(cls1) : '0;

    sched_resv_table #(.HORIZON(HORIZON)) table_i (
        .clk   (clk),
        .rst   (rst),
        .commit(commit),
        .occ   (occ)
    );
endmodule

// File: rtl/sched_checker.sv
module sched_checker
    import sched_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in0_valid,
    input logic [3:0]       in0_class,
    input logic             in1_valid,
    input logic [3:0]       in1_class,
    input logic             grant0,
    input logic [LAT_W-1:0] lat0,
    input logic             grant1,
    input logic [LAT_W-1:0] lat1
);
    iclass_e c0, c1;
    assign c0 = decode_class(in0_class);
    assign c1 = decode_class(in1_class);

    logic fp0, fp1, ls0, ls1;
    assign fp0 = (c0 == IC_FP) || (c0 == IC_FDIVS) || (c0 == IC_FDIVD);
    assign fp1 = (c1 == IC_FP) || (c1 == IC_FDIVS) || (c1 == IC_FDIVD);
    assign ls0 = (c0 == IC_LDST) || (c0 == IC_FPLD);
    assign ls1 = (c1 == IC_LDST) || (c1 == IC_FPLD);

    // R2
    order_chk: assert property (@(posedge clk) disable iff (rst)
        grant1 |-> (grant0 && in1_valid));

    // R2
    valid_chk: assert property (@(posedge clk) disable iff (rst)
        grant0 |-> in0_valid);

    // R12
    lat_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!grant0 |-> lat0 == '0) and (!grant1 |-> lat1 == '0));

    // R12
    lat_live_chk: assert property (@(posedge clk) disable iff (rst)
        (grant0 |-> lat0 != '0) and (grant1 |-> lat1 != '0));

    // R6
    mul_pair_chk: assert property (@(posedge clk) disable iff (rst)
        !(grant0 && grant1 && c0 == IC_MUL && c1 == IC_MUL));

    // R7
    div_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (grant0 && c0 == IC_DIV) |=>
            !(grant0 && c0 == IC_DIV) && !(grant1 && c1 == IC_DIV));

    // R8
    su1_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (grant0 && c0 == IC_MFCR) |=>
            !(grant0 && (c0 == IC_MTCR || c0 == IC_MFCR)));

    // R9
    bu_pair_chk: assert property (@(posedge clk) disable iff (rst)
        !(grant0 && grant1 && c0 == IC_BRANCH && c1 == IC_BRANCH));

    // R10
    lsu_pair_chk: assert property (@(posedge clk) disable iff (rst)
        !(grant0 && grant1 && ls0 && ls1));

    // R11
    fpu_pair_chk: assert property (@(posedge clk) disable iff (rst)
        !(grant0 && grant1 && fp0 && fp1));
endmodule

bind dual_issue_hazard_sched sched_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .in0_valid(in0_valid),
    .in0_class(in0_class),
    .in1_valid(in1_valid),
    .in1_class(in1_class),
    .grant0   (grant0),
    .lat0     (lat0),
    .grant1   (grant1),
    .lat1     (lat1)
);

// File: tb/dual_issue_hazard_sched_tb_top.sv
module dual_issue_hazard_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    localparam int C_SIMPLE = 0, C_CMP = 1, C_TWO = 2, C_THREE = 3, C_MUL = 4;
    localparam int C_DIV = 5, C_MFCR = 6, C_MTCR = 7, C_BRANCH = 8, C_LDST = 9;
    localparam int C_FPLD = 10, C_FP = 11, C_FDIVS = 12, C_FDIVD = 13;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in0_valid = 1'b0, in1_valid = 1'b0;
    logic [3:0] in0_class = '0, in1_class = '0;
    logic       grant0, grant1;
    logic [5:0] lat0, lat1;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        logic       g0;
        logic [5:0] l0;
        logic       g1;
        logic [5:0] l1;
        string      tag;
    } expect_t;

    expect_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_issue_hazard_sched dut_i (
        .clk(clk), .rst(rst),
        .in0_valid(in0_valid), .in0_class(in0_class),
        .in1_valid(in1_valid), .in1_class(in1_class),
        .grant0(grant0), .lat0(lat0), .grant1(grant1), .lat1(lat1)
    );

    function automatic logic [5:0] lat_of(input int c);
        case (c)
            1, 2:      return 6'd2;
            3, 9:      return 6'd3;
            4, 6, 10:  return 6'd4;
            5:         return 6'd14;
            11:        return 6'd7;
            12:        return 6'd20;
            13:        return 6'd35;
            default:   return 6'd1;
        endcase
    endfunction

    // Driver: present a pair and push the expected result
    task automatic req(input logic v0, input int c0, input logic v1, input int c1,
                       input logic eg0, input logic eg1, input string tag);
        expect_t e;
        @(negedge clk);
        in0_valid = v0; in0_class = 4'(c0);
        in1_valid = v1; in1_class = 4'(c1);
        e.g0 = eg0; e.l0 = eg0 ? lat_of(c0) : 6'd0;
        e.g1 = eg1; e.l1 = eg1 ? lat_of(c1) : 6'd0;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in0_valid = 1'b0; in1_valid = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        in0_valid = 1'b0; in1_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Monitor: compare a quarter period after inputs change
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (sb_q.size() > 0) begin
                expect_t e;
                e = sb_q.pop_front();
                checks++;
                if (grant0 !== e.g0 || lat0 !== e.l0 || grant1 !== e.g1 || lat1 !== e.l1) begin
                    failures++;
                    $display("FAIL %s: actual g0=%0b l0=%0d g1=%0b l1=%0d expected g0=%0b l0=%0d g1=%0b l1=%0d",
                             e.tag, grant0, lat0, grant1, lat1, e.g0, e.l0, e.g1, e.l1);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state, no valid
        req(0, C_SIMPLE, 0, C_SIMPLE, 0, 0, "R1 idle after reset");
        // R3 two simple
        req(1, C_SIMPLE, 1, C_SIMPLE, 1, 1, "R3 simple pair");
        idle(5);
        // R5 three-part holds slot 0 over three cycles; R2 partial stall
        req(1, C_THREE, 1, C_SIMPLE, 1, 1, "R5 three+simple");
        req(1, C_SIMPLE, 1, C_SIMPLE, 1, 0, "R5 R2 second slot taken");
        req(1, C_SIMPLE, 1, C_SIMPLE, 1, 0, "R5 third cycle");
        req(1, C_SIMPLE, 1, C_SIMPLE, 1, 1, "R5 released");
        idle(5);
        req(1, C_TWO, 1, C_THREE, 1, 1, "R5 two+three");
        req(1, C_SIMPLE, 0, C_SIMPLE, 0, 0, "R5 both slots busy");
        req(1, C_SIMPLE, 1, C_SIMPLE, 1, 0, "R5 one slot left");
        idle(5);
        // R4 compare retires one cycle later
        req(1, C_CMP, 1, C_CMP, 1, 1, "R4 compare pair");
        req(1, C_SIMPLE, 0, C_SIMPLE, 0, 0, "R4 retire slots full");
        req(1, C_SIMPLE, 1, C_SIMPLE, 1, 1, "R4 retire free again");
        idle(5);
        // R6 multiplier
        req(1, C_MUL, 1, C_MUL, 1, 0, "R6 one multiply per cycle");
        req(1, C_MUL, 1, C_DIV, 1, 0, "R6 R7 stage 0 shared");
        req(1, C_MUL, 0, C_SIMPLE, 1, 0, "R6 back-to-back multiply");
        idle(6);
        // R7 divider hold
        req(1, C_DIV, 0, C_SIMPLE, 1, 0, "R7 divide start");
        req(1, C_DIV, 1, C_SIMPLE, 0, 0, "R2 stalled lane 0 blocks lane 1");
        idle(11);
        req(1, C_DIV, 0, C_SIMPLE, 0, 0, "R7 divider still held");
        req(1, C_DIV, 0, C_SIMPLE, 1, 0, "R7 divider released");
        idle(16);
        // R8 unit 1 only
        req(1, C_MFCR, 1, C_MTCR, 1, 0, "R8 unit 1 taken by mfcr");
        req(1, C_SIMPLE, 1, C_MTCR, 1, 0, "R8 simple uses unit 0");
        req(1, C_MTCR, 0, C_SIMPLE, 0, 0, "R8 hold cycle 3");
        req(1, C_MTCR, 0, C_SIMPLE, 0, 0, "R8 hold cycle 4");
        req(1, C_SIMPLE, 1, C_MTCR, 1, 1, "R3 R8 slot 0 preference");
        idle(5);
        // R9 branch
        req(1, C_TWO, 1, C_TWO, 1, 1, "R9 fill issue");
        req(1, C_BRANCH, 1, C_SIMPLE, 1, 0, "R9 branch needs no issue slot");
        req(1, C_BRANCH, 1, C_BRANCH, 1, 0, "R9 one branch per cycle");
        idle(5);
        // R10 load/store unit
        req(1, C_LDST, 1, C_LDST, 1, 0, "R10 one lsu op");
        req(1, C_FPLD, 1, C_LDST, 1, 0, "R10 fp load");
        req(1, C_SIMPLE, 1, C_LDST, 1, 1, "R10 R12 lane 1 latency");
        idle(6);
        // R11 FPU
        req(1, C_FP, 1, C_FP, 1, 0, "R11 one fp per cycle");
        req(1, C_FDIVS, 1, C_FP, 1, 0, "R11 single divide start");
        idle(18);
        req(1, C_FP, 0, C_SIMPLE, 0, 0, "R11 single divide held");
        req(1, C_FP, 0, C_SIMPLE, 1, 0, "R11 single divide released");
        idle(3);
        req(1, C_FDIVD, 0, C_SIMPLE, 1, 0, "R11 double divide start");
        idle(33);
        req(1, C_FP, 0, C_SIMPLE, 0, 0, "R11 double divide held");
        req(1, C_FP, 0, C_SIMPLE, 1, 0, "R11 double divide released");
        idle(3);
        // R1 reset clears bookings
        req(1, C_FDIVD, 0, C_SIMPLE, 1, 0, "R1 long hold booked");
        req(1, C_FP, 0, C_SIMPLE, 0, 0, "R1 blocked before reset");
        do_reset();
        req(1, C_FP, 0, C_SIMPLE, 1, 0, "R1 cleared by reset");
        idle(40);
        // R12 latency sweep over all codes
        for (int c = 0; c < 16; c++) begin
            req(1, c, 0, C_SIMPLE, 1, 0, "R12 latency sweep");
            idle(40);
        end
        req(1, C_SIMPLE, 1, C_CMP, 1, 1, "R12 lane 1 compare latency");
        idle(3);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule